// File: doc/BRIEF.md
# Parallel Port Command/Status Unit

This block is the register front end of a byte-wide parallel I/O unit. A host on a synchronous bus selects it with a chip enable and an I/O-select line, then reads or writes one of a few byte registers. Offset zero is shared. A write there loads a write-only command byte, which sets the direction of two 8-bit ports, picks one of four roles for a 6-bit control port, and holds the two port interrupt enables. A read at offset zero returns a status byte that reports handshake and interrupt state. The command byte itself can never be read back.

Every port pin is split into separate input, output and output-enable signals. Ports A and B work either as plain latched outputs or pass-through inputs, or with a simplified strobed handshake. In the handshake, the control port carries each port's interrupt request, buffer-full flag and strobe. The two timer-command bits of the command byte are handed on unchanged to a separate timer block. That block's flag comes back in as an input and appears in the status byte.

Top module: `pport_ctrl`

## Requirements
- R1: After reset every output enable is 0, the port output latches are 0, `tmr_cmd` is 0 and a status read returns 0x00 when `tmr_flag` is low.
- R2: A write at offset 0 loads the command byte. A read at offset 0 returns the status byte, laid out as bit0 A request, bit1 A buffer-full, bit2 A enable (command bit 4), bit3 B request, bit4 B buffer-full, bit5 B enable (command bit 5). Command bits 7:6 appear on `tmr_cmd`.
- R3: Command bit 0 set drives `pa_oe` to all ones and bit 1 set drives `pb_oe` to all ones; a cleared bit makes the port an input. A write at offset 1 or 2 loads the output latch shown on `pa_out` or `pb_out`.
- R4: Command bits 3:2 set `pc_oe`: 00 gives 0x00 (all inputs), 11 gives 0x3F (all outputs), 01 gives 0x3B (PC0 A request out, PC1 A buffer-full out, PC2 A strobe in, PC5..PC3 outputs), and 10 gives 0x1B (the same for A, plus PC3 B request out, PC4 B buffer-full out, PC5 B strobe in).
- R5: Outside the strobed handshake, a read of port A or B returns the pins when the port is an input and the output latch when it is an output.
- R6: A read at offset 3 returns the pin value for each control-port bit whose enable is 0 and the driven value for each bit whose enable is 1, with bits 7:6 zero. In modes 00 and 11, a write at offset 3 sets the driven value.
- R7: In strobed input mode, the pins are latched and buffer-full is set while the strobe is low. A later port read returns the latched byte even after the pins change.
- R8: A strobe rising edge raises the port's interrupt request only when its enable bit is 1. The request is driven on PC0 for A and PC3 for B, and buffer-full on PC1 and PC4.
- R9: A read of a port in strobed input mode clears its buffer-full flag and its interrupt request.
- R10: In strobed output mode, a port write sets buffer-full, a low strobe clears it, and the strobe rising edge raises the request if it is enabled.
- R11: With `cs` or `io_sel` low, writes change nothing and `rdata` is 0.
- R12: Status bit 6 follows `tmr_flag` and bit 7 always reads 0.
- R13: Offsets 4 to 7 belong to another block. Writes there change no register here, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip enable, active high |
| io_sel | input | 1 | I/O space select, high for register access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| tmr_flag | input | 1 | Terminal-count flag from the timer block |
| tmr_cmd | output | 2 | Timer command bits for the timer block |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A pin output |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B pin output |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 6 | Control port pin input |
| pc_out | output | 6 | Control port pin output |
| pc_oe | output | 6 | Control port output enable |

## Verification
The command decode is walked with a table of command bytes. Each byte isolates one direction bit, one control-port role, one enable bit, or the timer bits, so an entry that fails names the field that is decoded wrongly. The strobed paths are tried as input and as output, with the interrupt enabled and disabled. The pins are changed after the strobe, which tells a true latch apart from a pass-through. Port B's handshake is only available in the fourth role, and it is checked there so that a swapped role encoding shows up.

// File: rtl/pport_ctrl.sv
module pport_ctrl #(
  parameter int DW = 8,
  parameter int CW = 6,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          io_sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          tmr_flag,
  output logic [1:0]    tmr_cmd,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [CW-1:0] pc_in,
  output logic [CW-1:0] pc_out,
  output logic [CW-1:0] pc_oe
);
  localparam logic [AW-1:0] OFS_CS = AW'(0);
  localparam logic [AW-1:0] OFS_PA = AW'(1);
  localparam logic [AW-1:0] OFS_PB = AW'(2);
  localparam logic [AW-1:0] OFS_PC = AW'(3);

  logic [7:0]    cmd;
  logic [CW-1:0] pc_r;

  wire acc   = cs & io_sel;
  wire wr_en = acc & wr;
  wire rd_en = acc & rd;

  wire [1:0] pmode = cmd[3:2];
  wire [1:0] dir   = cmd[1:0];
  wire [1:0] ie    = cmd[5:4];
  wire [1:0] hs_en = {pmode == 2'b10, pmode == 2'b01 || pmode == 2'b10};
  wire [1:0] stb   = {pc_in[5], pc_in[2]};

  wire [1:0][DW-1:0] pin     = {pb_in, pa_in};
  wire [1:0]         port_wr = {wr_en && addr == OFS_PB, wr_en && addr == OFS_PA};
  wire [1:0]         port_rd = {rd_en && addr == OFS_PB, rd_en && addr == OFS_PA};

  logic [1:0][DW-1:0] oreg, prd;
  logic [1:0]         bf, irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= '0;
      pc_r <= '0;
    end else if (wr_en) begin
      if (addr == OFS_CS) cmd  <= wdata;
      if (addr == OFS_PC) pc_r <= wdata[CW-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic          stb_q, bf_r, irq_r;
    logic [DW-1:0] lat, outr;
    wire rise = !stb_q && stb[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stb_q <= 1'b1;
        bf_r  <= 1'b0;
        irq_r <= 1'b0;
        lat   <= '0;
        outr  <= '0;
      end else begin
        stb_q <= stb[g];
        if (port_wr[g]) outr <= wdata[DW-1:0];
        if (!hs_en[g]) begin
          bf_r  <= 1'b0;
          irq_r <= 1'b0;
        end else if (dir[g]) begin
          if (port_wr[g]) begin
            bf_r  <= 1'b1;
            irq_r <= 1'b0;
          end else begin
            if (!stb[g]) bf_r <= 1'b0;
            if (rise && ie[g]) irq_r <= 1'b1;
          end
        end else begin
          if (!stb[g]) begin
            lat  <= pin[g];
            bf_r <= 1'b1;
          end else if (port_rd[g]) begin
            bf_r <= 1'b0;
          end
          if (rise && ie[g]) irq_r <= 1'b1;
          else if (port_rd[g]) irq_r <= 1'b0;
        end
        if (!ie[g]) irq_r <= 1'b0;
      end
    end

    assign bf[g]   = bf_r;
    assign irq[g]  = irq_r;
    assign oreg[g] = outr;
    assign prd[g]  = dir[g] ? outr : (hs_en[g] ? lat : pin[g]);
  end

  assign pa_out  = oreg[0];
  assign pb_out  = oreg[1];
  assign pa_oe   = {DW{dir[0]}};
  assign pb_oe   = {DW{dir[1]}};
  assign tmr_cmd = cmd[7:6];

  always_comb begin
    case (pmode)
      2'b00: begin pc_oe = '0;         pc_out = pc_r; end
      2'b11: begin pc_oe = '1;         pc_out = pc_r; end
      2'b01: begin pc_oe = 6'b111011;  pc_out = {pc_r[5:3], 1'b0, bf[0], irq[0]}; end
      default: begin pc_oe = 6'b011011; pc_out = {1'b0, bf[1], irq[1], 1'b0, bf[0], irq[0]}; end
    endcase
  end

  wire [7:0] status = {1'b0, tmr_flag, ie[1], bf[1], irq[1], ie[0], bf[0], irq[0]};
  wire [CW-1:0] pc_rd = (pc_in & ~pc_oe) | (pc_out & pc_oe);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_CS:  rdata = status;
        OFS_PA:  rdata = prd[0];
        OFS_PB:  rdata = prd[1];
        OFS_PC:  rdata = {{(8-CW){1'b0}}, pc_rd};
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       io_sel,
  input logic       rd,
  input logic       wr,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       tmr_flag,
  input logic [7:0] cmd,
  input logic [1:0] bf,
  input logic [1:0] irq,
  input logic [5:0] pc_in
);
  // R2
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && io_sel && wr && addr == 3'd0) |=> cmd == $past(wdata));

  // R11
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && io_sel) |=> $stable(cmd));

  // R12
  status_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && io_sel && rd && addr == 3'd0) |-> (rdata[7] == 1'b0 && rdata[6] == tmr_flag));

  // R8
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> $past(cmd[4]));

  // R13
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && io_sel && rd && addr[2]) |-> rdata == 8'h00);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && io_sel && rd && !wr && addr == 3'd1 && !cmd[0] && pc_in[2] &&
     (cmd[3:2] == 2'b01 || cmd[3:2] == 2'b10)) |=> !bf[0]);
endmodule

bind pport_ctrl pport_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .io_sel(io_sel), .rd(rd), .wr(wr),
  .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_flag(tmr_flag),
  .cmd(cmd), .bf(bf), .irq(irq), .pc_in(pc_in)
);

// File: tb/pport_ctrl_bench.sv
module pport_ctrl_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, cs, io_sel, rd, wr, tmr_flag;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic [5:0] pc_in, pc_out, pc_oe;
  logic [1:0] tmr_cmd;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pport_ctrl u_pport_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .io_sel(io_sel), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_flag(tmr_flag), .tmr_cmd(tmr_cmd),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // {cmd, pa_oe, pb_oe, pc_oe, status}
  localparam logic [37:0] VEC [10] = '{
    {8'h00, 8'h00, 8'h00, 6'h00, 8'h00},
    {8'h01, 8'hFF, 8'h00, 6'h00, 8'h00},
    {8'h02, 8'h00, 8'hFF, 6'h00, 8'h00},
    {8'h0C, 8'h00, 8'h00, 6'h3F, 8'h00},
    {8'h04, 8'h00, 8'h00, 6'h3B, 8'h00},
    {8'h08, 8'h00, 8'h00, 6'h1B, 8'h00},
    {8'h13, 8'hFF, 8'hFF, 6'h00, 8'h04},
    {8'h23, 8'hFF, 8'hFF, 6'h00, 8'h20},
    {8'h3F, 8'hFF, 8'hFF, 6'h3F, 8'h24},
    {8'hC0, 8'h00, 8'h00, 6'h00, 8'h00}
  };

  task automatic idle();
    cs = 0; io_sel = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d,
                        input logic c = 1'b1, input logic io = 1'b1);
    @(negedge clk);
    cs = c; io_sel = io; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 idle();
  endtask

  task automatic bus_rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag,
                            input logic c = 1'b1, input logic io = 1'b1);
    logic [7:0] d;
    @(negedge clk);
    cs = c; io_sel = io; rd = 1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 idle();
    chk(tag, d, exp);
  endtask

  task automatic strobe(input int bit_idx, input logic sel_b,
                        input logic [7:0] d_low, input logic [7:0] d_high);
    @(negedge clk);
    pc_in[bit_idx] = 1'b0;
    if (sel_b) pb_in = d_low; else pa_in = d_low;
    @(negedge clk);
    pc_in[bit_idx] = 1'b1;
    if (sel_b) pb_in = d_high; else pa_in = d_high;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; tmr_flag = 0; pa_in = '0; pb_in = '0; pc_in = 6'h3F;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", {2'b0, pc_oe}, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 tmr_cmd", {6'b0, tmr_cmd}, 8'h00);
    bus_rd_chk(3'd0, 8'h00, "R1 status");

    // R2 R3 R4 command decode table
    for (int i = 0; i < 10; i++) begin
      bus_wr(3'd0, VEC[i][37:30]);
      chk("R3 pa_oe", pa_oe, VEC[i][29:22]);
      chk("R3 pb_oe", pb_oe, VEC[i][21:14]);
      chk("R4 pc_oe", {2'b0, pc_oe}, {2'b0, VEC[i][13:8]});
      chk("R2 tmr_cmd", {6'b0, tmr_cmd}, {6'b0, VEC[i][37:36]});
      bus_rd_chk(3'd0, VEC[i][7:0], "R2 status");
    end

    // R5 basic ports
    bus_wr(3'd0, 8'h00);
    pa_in = 8'hA5;
    bus_rd_chk(3'd1, 8'hA5, "R5 A input");
    bus_wr(3'd0, 8'h01);
    bus_wr(3'd1, 8'h3C);
    chk("R3 pa_out", pa_out, 8'h3C);
    bus_rd_chk(3'd1, 8'h3C, "R5 A output");

    // R12 timer flag
    tmr_flag = 1;
    bus_rd_chk(3'd0, 8'h40, "R12 status");
    // R11 no access without both selects
    bus_rd_chk(3'd0, 8'h00, "R11 cs low read", 1'b0, 1'b1);
    bus_rd_chk(3'd0, 8'h00, "R11 io low read", 1'b1, 1'b0);
    tmr_flag = 0;
    bus_wr(3'd0, 8'h00, 1'b0, 1'b1);
    chk("R11 cs low write", pa_oe, 8'hFF);
    bus_wr(3'd0, 8'h00, 1'b1, 1'b0);
    chk("R11 io low write", pa_oe, 8'hFF);

    // R13 foreign offsets
    bus_wr(3'd4, 8'hFF);
    bus_wr(3'd5, 8'hFF);
    chk("R13 pa_out kept", pa_out, 8'h3C);
    chk("R13 pa_oe kept", pa_oe, 8'hFF);
    bus_rd_chk(3'd0, 8'h00, "R13 status kept");
    bus_rd_chk(3'd5, 8'h00, "R13 read 5");
    bus_rd_chk(3'd7, 8'h00, "R13 read 7");

    // R6 control port reads
    bus_wr(3'd0, 8'h00);
    pc_in = 6'h2A;
    bus_rd_chk(3'd3, 8'h2A, "R6 inputs");
    pc_in = 6'h3F;
    bus_rd_chk(3'd3, 8'h3F, "R6 upper zero");
    bus_wr(3'd0, 8'h0C);
    bus_wr(3'd3, 8'h15);
    chk("R6 pc_out", {2'b0, pc_out}, 8'h15);
    bus_rd_chk(3'd3, 8'h15, "R6 outputs");
    bus_wr(3'd0, 8'h04);
    bus_rd_chk(3'd3, 8'h14, "R6 mixed role");

    // R7 R8 R9 strobed input on A
    bus_wr(3'd0, 8'h14);
    strobe(2, 1'b0, 8'h5A, 8'hFF);
    chk("R8 pc_out A", {6'b0, pc_out[1:0]}, 8'h03);
    bus_rd_chk(3'd0, 8'h07, "R7 status");
    bus_rd_chk(3'd1, 8'h5A, "R7 latched");
    bus_rd_chk(3'd0, 8'h04, "R9 cleared");
    chk("R9 pc_out A", {6'b0, pc_out[1:0]}, 8'h00);

    // R8 disabled interrupt
    bus_wr(3'd0, 8'h04);
    strobe(2, 1'b0, 8'h11, 8'h22);
    bus_rd_chk(3'd0, 8'h02, "R8 no request");
    chk("R8 pc0 low", {7'b0, pc_out[0]}, 8'h00);
    bus_rd_chk(3'd1, 8'h11, "R7 latched 2");

    // R10 strobed output on A
    bus_wr(3'd0, 8'h15);
    bus_wr(3'd1, 8'h77);
    chk("R10 pa_out", pa_out, 8'h77);
    bus_rd_chk(3'd0, 8'h06, "R10 full");
    strobe(2, 1'b0, 8'h00, 8'h00);
    bus_rd_chk(3'd0, 8'h05, "R10 ack");
    chk("R10 pc0", {7'b0, pc_out[0]}, 8'h01);

    // R8 R9 port B handshake in the fourth role
    bus_wr(3'd0, 8'h28);
    strobe(5, 1'b1, 8'hC3, 8'h00);
    bus_rd_chk(3'd0, 8'h38, "R8 B status");
    chk("R8 pc_out B", {6'b0, pc_out[4:3]}, 8'h03);
    bus_rd_chk(3'd2, 8'hC3, "R7 B latched");
    bus_rd_chk(3'd0, 8'h20, "R9 B cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule